// File: doc/BRIEF.md
# Mixed-Radix Delay Step Counter

This block holds the delay setting for one read-strobe delay line as four fields: a 4-bit coarse count, a 2-bit medium count, a tap count that runs from 0 to 14, and a 3-bit interpolator phase. A calibration sequencer moves the setting through single-cycle step commands. It can step the medium field up or down, or step the tap field up or down. A step that runs off the end of a field carries into the next coarser field, or borrows from it.

The coarse field does not wrap. A step that would take the whole setting past its lowest or highest point is refused. In that case the setting stays exactly as it was, and an error pulse lasting one cycle is raised. The sequencer can also load all four fields at once, or write only the interpolator phase. The block drives the fields onto its outputs, together with a packed fine byte for the delay line.

Every change is registered. A command presented before a rising edge shows on the outputs, and on the error pulse, right after that edge.

Top module: `mr_delay_step`

## Requirements
- R1: A synchronous active-high reset clears coarse, medium, tap, phase and the error pulse to zero.
- R2: When `load_en` is high, all four fields take the load values at the next edge, and no error is raised. A tap load value above 14 is stored as 14.
- R3: A medium up-step adds one to medium. From medium 3 it sets medium to 0 and adds one to coarse. Tap and phase are left unchanged.
- R4: A medium down-step subtracts one from medium. From medium 0 it sets medium to 3 and subtracts one from coarse. Tap and phase are left unchanged.
- R5: A medium up-step at medium 3 with coarse 15 fails, and so does a medium down-step at medium 0 with coarse 0. A failed step leaves every field unchanged and raises `step_err`.
- R6: A tap up-step below 14 adds one to tap. At tap 14 it performs a medium up-step and sets tap to 0. If that medium step would fail (R5), the whole step fails and nothing changes.
- R7: A tap down-step above 0 subtracts one from tap. At tap 0 it performs a medium down-step and sets tap to 14. If that medium step would fail, the whole step fails and nothing changes.
- R8: `step_err` is high for exactly the one cycle after the edge that refused a step. It is low after any edge that did not refuse a step.
- R9: `phase_wr` replaces only the phase field with `phase_val`. It takes effect together with a step in the same cycle. A load in the same cycle overrides it, and the phase then comes from the load.
- R10: At most one command is carried out per edge. The priority is: load, then medium up, then tap up, then medium down, then tap down.
- R11: `fine_o` carries tap in bits 3:0 and phase in bits 6:4, with bit 7 held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load all fields |
| load_coarse | input | 4 | Coarse value to load |
| load_medium | input | 2 | Medium value to load |
| load_tap | input | 4 | Tap value to load (saturates at 14) |
| load_phase | input | 3 | Phase value to load |
| phase_wr | input | 1 | Write the phase field only |
| phase_val | input | 3 | Phase value for `phase_wr` |
| med_up | input | 1 | Medium up-step |
| med_dn | input | 1 | Medium down-step |
| tap_up | input | 1 | Tap up-step |
| tap_dn | input | 1 | Tap down-step |
| coarse_o | output | 4 | Coarse field |
| medium_o | output | 2 | Medium field |
| tap_o | output | 4 | Tap field |
| phase_o | output | 3 | Phase field |
| fine_o | output | 8 | Packed fine byte |
| step_err | output | 1 | One-cycle pulse after a refused step |

## Verification
The bench loads every legal combination of coarse, medium and tap, and tries each of the four step commands from each one. The expected result is computed from a single linear position, which tells a correct carry or borrow apart from a wrap and from an error wrongly raised or wrongly missed. Most loaded states sit away from the limits and test plain stepping. The two extreme corners are the only places where a failure is expected, so they show whether a refused step really leaves the setting untouched. Directed cases then pair commands in one cycle to test the priority order, combine phase writes with loads and with steps, and confirm that the error pulse drops after one cycle.

// File: rtl/mr_delay_step.sv
module mr_delay_step #(
  parameter int CW      = 4,
  parameter int MW      = 2,
  parameter int TW      = 4,
  parameter int TAP_MAX = 14,
  parameter int PW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CW-1:0]    load_coarse,
  input  logic [MW-1:0]    load_medium,
  input  logic [TW-1:0]    load_tap,
  input  logic [PW-1:0]    load_phase,
  input  logic             phase_wr,
  input  logic [PW-1:0]    phase_val,
  input  logic             med_up,
  input  logic             med_dn,
  input  logic             tap_up,
  input  logic             tap_dn,
  output logic [CW-1:0]    coarse_o,
  output logic [MW-1:0]    medium_o,
  output logic [TW-1:0]    tap_o,
  output logic [PW-1:0]    phase_o,
  output logic [PW+TW:0]   fine_o,
  output logic             step_err
);
  localparam int PosW = CW + MW;
  localparam logic [TW-1:0]   TMax   = TW'(TAP_MAX);
  localparam logic [PosW-1:0] PosTop = '1;

  logic [PosW-1:0] pos_q, pos_d;
  logic [TW-1:0]   tap_q, tap_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic            err_q, fail;

  wire at_top = (pos_q == PosTop);
  wire at_bot = (pos_q == '0);

  always_comb begin
    pos_d = pos_q;
    tap_d = tap_q;
    fail  = 1'b0;
    if (load_en) begin
      pos_d = {load_coarse, load_medium};
      tap_d = (load_tap > TMax) ? TMax : load_tap;
    end else if (med_up) begin
      if (at_top) fail = 1'b1;
      else        pos_d = pos_q + 1'b1;
    end else if (tap_up) begin
      if (tap_q != TMax)  tap_d = tap_q + 1'b1;
      else if (at_top)    fail = 1'b1;
      else begin
        pos_d = pos_q + 1'b1;
        tap_d = '0;
      end
    end else if (med_dn) begin
      if (at_bot) fail = 1'b1;
      else        pos_d = pos_q - 1'b1;
    end else if (tap_dn) begin
      if (tap_q != '0) tap_d = tap_q - 1'b1;
      else if (at_bot) fail = 1'b1;
      else begin
        pos_d = pos_q - 1'b1;
        tap_d = TMax;
      end
    end
  end

  assign ph_d = load_en ? load_phase : (phase_wr ? phase_val : ph_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      tap_q <= '0;
      ph_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      tap_q <= tap_d;
      ph_q  <= ph_d;
      err_q <= fail;
    end
  end

  assign coarse_o = pos_q[PosW-1:MW];
  assign medium_o = pos_q[MW-1:0];
  assign tap_o    = tap_q;
  assign phase_o  = ph_q;
  assign fine_o   = {1'b0, ph_q, tap_q};
  assign step_err = err_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (coarse_o == '0 && medium_o == '0 && tap_o == '0 && phase_o == '0 && !step_err));

  assert_load_no_err_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_en)) |-> (!step_err && tap_o <= TMax));

  assert_med_up_adds_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!load_en && med_up) && !step_err)
      |-> ({coarse_o, medium_o} == $past({coarse_o, medium_o}) + 1'b1 && $stable(tap_o)));

  assert_fail_keeps_state_R5: assert property (@(posedge clk) disable iff (rst)
    step_err |-> ($stable(coarse_o) && $stable(medium_o) && $stable(tap_o)));

  assert_tap_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    tap_o <= TMax);

  assert_err_after_step_R8: assert property (@(posedge clk) disable iff (rst)
    step_err |-> $past(!load_en && (med_up || med_dn || tap_up || tap_dn)));
endmodule

// File: tb/mr_delay_step_bench.sv
module mr_delay_step_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic load_en = 0, phase_wr = 0, med_up = 0, med_dn = 0, tap_up = 0, tap_dn = 0;
  logic [3:0] load_coarse = 0, load_tap = 0;
  logic [1:0] load_medium = 0;
  logic [2:0] load_phase = 0, phase_val = 0;
  logic [3:0] coarse_o, tap_o;
  logic [1:0] medium_o;
  logic [2:0] phase_o;
  logic [7:0] fine_o;
  logic       step_err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mr_delay_step u_mr_delay_step (
    .clk(clk), .rst(rst), .load_en(load_en), .load_coarse(load_coarse),
    .load_medium(load_medium), .load_tap(load_tap), .load_phase(load_phase),
    .phase_wr(phase_wr), .phase_val(phase_val), .med_up(med_up), .med_dn(med_dn),
    .tap_up(tap_up), .tap_dn(tap_dn), .coarse_o(coarse_o), .medium_o(medium_o),
    .tap_o(tap_o), .phase_o(phase_o), .fine_o(fine_o), .step_err(step_err)
  );

  task automatic expect_state(string req, int c, int m, int t, int p, bit e);
    int fexp;
    fexp = p * 16 + t;
    checks++;
    if (coarse_o != c || medium_o != m || tap_o != t || phase_o != p ||
        step_err != e || fine_o != fexp) begin
      errors++;
      $display("FAIL %s: got c=%0d m=%0d t=%0d p=%0d err=%0d fine=%0h, expected c=%0d m=%0d t=%0d p=%0d err=%0d fine=%0h",
               req, coarse_o, medium_o, tap_o, phase_o, step_err, fine_o, c, m, t, p, e, fexp);
    end
  endtask

  task automatic clear_cmds();
    load_en = 0; phase_wr = 0; med_up = 0; med_dn = 0; tap_up = 0; tap_dn = 0;
  endtask

  task automatic do_load(int c, int m, int t, int p);
    load_en = 1; load_coarse = 4'(c); load_medium = 2'(m); load_tap = 4'(t); load_phase = 3'(p);
    @(negedge clk);
    clear_cmds();
  endtask

  task automatic step(bit mu, bit tu, bit md, bit td);
    med_up = mu; tap_up = tu; med_dn = md; tap_dn = td;
    @(negedge clk);
    clear_cmds();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    load_en = 1; load_coarse = 9; load_medium = 2; load_tap = 7; load_phase = 5;
    repeat (3) @(negedge clk);
    clear_cmds();
    rst = 0;
    expect_state("R1 reset", 0, 0, 0, 0, 0);

    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 15; t++)
          for (int op = 0; op < 4; op++) begin
            int pos, tot, ec, em, et, p;
            bit f;
            string tag;
            p = (c + t) % 8;
            do_load(c, m, t, p);
            if (op == 0) expect_state("R2 load", c, m, t, p, 0);
            pos = c * 4 + m;
            tot = pos * 15 + t;
            f = 0;
            case (op)
              0: begin tag = "R3 med up"; f = (pos == 63); if (!f) pos++; step(1,0,0,0); end
              1: begin tag = "R4 med down"; f = (pos == 0); if (!f) pos--; step(0,0,1,0); end
              2: begin tag = "R6 tap up"; f = (tot == 959); if (!f) tot++; step(0,1,0,0); end
              default: begin tag = "R7 tap down"; f = (tot == 0); if (!f) tot--; step(0,0,0,1); end
            endcase
            if (op < 2) begin ec = pos / 4; em = pos % 4; et = t; end
            else begin ec = (tot / 15) / 4; em = (tot / 15) % 4; et = tot % 15; end
            if (f && op < 2) tag = "R5 medium limit";
            expect_state(tag, ec, em, et, p, f);
            if (f) begin
              @(negedge clk);
              expect_state("R8 pulse drops", ec, em, et, p, 0);
            end
          end

    // R2 tap clamp
    do_load(3, 1, 15, 2);
    expect_state("R2 tap clamp", 3, 1, 14, 2, 0);
    // R9 phase write alone, then with a step, then overridden by load
    phase_wr = 1; phase_val = 6; @(negedge clk); clear_cmds();
    expect_state("R9 phase write", 3, 1, 14, 6, 0);
    phase_wr = 1; phase_val = 1; step(0,1,0,0);
    expect_state("R9 phase with step", 3, 2, 0, 1, 0);
    phase_wr = 1; phase_val = 7; do_load(5, 0, 4, 3);
    expect_state("R9 load beats phase", 5, 0, 4, 3, 0);
    // R10 priority
    med_up = 1; tap_dn = 1; do_load(8, 3, 9, 2);
    expect_state("R10 load first", 8, 3, 9, 2, 0);
    step(1,1,1,1);
    expect_state("R10 med up first", 9, 0, 9, 2, 0);
    step(0,1,1,1);
    expect_state("R10 tap up second", 9, 0, 10, 2, 0);
    step(0,0,1,1);
    expect_state("R10 med down third", 8, 3, 10, 2, 0);
    // R8 error at top then successful step clears pulse
    do_load(15, 3, 14, 4);
    step(0,1,0,0);
    expect_state("R6 top fail", 15, 3, 14, 4, 1);
    step(0,0,0,1);
    expect_state("R8 cleared by good step", 15, 3, 13, 4, 0);
    // R11 fine byte with bit7 low at max phase
    phase_wr = 1; phase_val = 7; @(negedge clk); clear_cmds();
    checks++;
    if (fine_o != 8'h7d) begin
      errors++;
      $display("FAIL R11 fine byte: got %0h, expected 7d", fine_o);
    end
    // R1 reset mid-run
    rst = 1; @(negedge clk); rst = 0;
    expect_state("R1 reset again", 0, 0, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule